// File: doc/BRIEF.md
# UART Receive Queue with Flow Control

This block sits between a UART deserializer and a register bus. Each received byte comes in on a one-cycle valid strobe and is stored in a first-in first-out queue. The byte at the head of the queue is always visible on the read data port. A read request removes that byte. The same data port serves both the arrival side and the bus side, so software reads one address and gets the bytes in the order they arrived.

The block derives four indications from its single fill count:
- an RTS output that tells the far sender to pause;
- a level flag that asks software to service the queue;
- a one-cycle overflow pulse when a byte is lost;
- a sticky idle-timeout flag.

The timeout flag measures line silence in character times. The block counts per-bit ticks from the baud generator and groups them by the configured frame length. Serial framing, parity and the interrupt register set belong to other blocks.

Top module: `uart_rx_queue`

## Requirements
- R1: Bytes are returned in arrival order. `rd_data` shows the oldest stored byte, and a read request with the queue non-empty removes it at the next clock edge.
- R2: `fill` equals the number of stored bytes, from 0 to DEPTH.
- R3: `rts` is 1 exactly while `rts_en` is 1 and `fill` is greater than `rts_thr`.
- R4: `full_evt` is 1 exactly while `fill` is greater than `full_thr`. It falls once the queue is drained to `full_thr` or below.
- R5: A byte that arrives while DEPTH bytes are stored and no read removes one in the same cycle is discarded. `ovf_evt` pulses high for the one cycle after that edge.
- R6: An arrival and a read in the same cycle on a non-empty queue leave `fill` unchanged. This holds when the queue is full, in which case the arriving byte is kept.
- R7: A read request on an empty queue has no effect, and `rd_data` reads 0 while the queue is empty.
- R8: One character time is `frame_bits` pulses of `bit_tick`. The idle count advances once per character time while the queue holds data. It restarts, together with the partial character, on any arrival strobe, on any effective read, and while the queue is empty.
- R9: When `tout_en` is 1 and the idle count exceeds `tout_thr`, `tout_evt` becomes 1 at the next edge. It stays 1 until the queue becomes empty.
- R10: After reset, `fill` is 0, `rd_data` is 0, and `rts`, `full_evt`, `ovf_evt` and `tout_evt` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Received byte strobe from the deserializer |
| wr_data | input | 8 | Received byte |
| rd_req | input | 1 | Bus read: pop the head byte |
| rd_data | output | 8 | Head byte, 0 when empty |
| fill | output | $clog2(DEPTH+1) | Stored byte count |
| rts_en | input | 1 | Receive flow control enable |
| rts_thr | input | $clog2(DEPTH) | Flow control level |
| full_thr | input | $clog2(DEPTH) | Service request level |
| tout_en | input | 1 | Idle timeout enable |
| tout_thr | input | TOUT_W | Idle timeout limit in character times |
| bit_tick | input | 1 | One pulse per serial bit time |
| frame_bits | input | FRM_W | Bits per character, 1 or more |
| rts | output | 1 | Flow control output, high asks the sender to stop |
| full_evt | output | 1 | Fill level above `full_thr` |
| ovf_evt | output | 1 | Byte lost on a full queue |
| tout_evt | output | 1 | Idle timeout reached |

## Verification
The bench builds the block with DEPTH = 16 and TOUT_W = 3. With these values the queue fills in sixteen arrivals, so the overflow and simultaneous-push-and-pop-at-full cases are hit many times in a short run. Every threshold value, including the top value, can be swept. The small timeout field lets the idle count reach its saturation value. A three-bit frame length keeps character times to a few cycles, so both the restart rule and the sticky clearing on drain come up often in directed and random traffic.

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH  = 128,
  parameter int TOUT_W = 7,
  parameter int FRM_W  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_valid,
  input  logic [7:0]                   wr_data,
  input  logic                         rd_req,
  output logic [7:0]                   rd_data,
  output logic [$clog2(DEPTH+1)-1:0]   fill,
  input  logic                         rts_en,
  input  logic [$clog2(DEPTH)-1:0]     rts_thr,
  input  logic [$clog2(DEPTH)-1:0]     full_thr,
  input  logic                         tout_en,
  input  logic [TOUT_W-1:0]            tout_thr,
  input  logic                         bit_tick,
  input  logic [FRM_W-1:0]             frame_bits,
  output logic                         rts,
  output logic                         full_evt,
  output logic                         ovf_evt,
  output logic                         tout_evt
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int IDLE_W = TOUT_W + 1;

  logic [7:0]        mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  cnt, cnt_nx;
  logic [FRM_W-1:0]  bit_cnt;
  logic [IDLE_W-1:0] idle;

  wire empty    = (cnt == '0);
  wire full     = (cnt == CNT_W'(DEPTH));
  wire do_pop   = rd_req && !empty;
  wire do_push  = wr_valid && (!full || do_pop);
  wire restart  = empty || wr_valid || do_pop;
  wire char_end = bit_tick && (bit_cnt + FRM_W'(1) == frame_bits);

  always_comb begin
    cnt_nx = cnt;
    if (do_push && !do_pop) cnt_nx = cnt + CNT_W'(1);
    else if (do_pop && !do_push) cnt_nx = cnt - CNT_W'(1);
  end

  always_ff @(posedge clk)
    if (do_push) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      ovf_evt  <= 1'b0;
      tout_evt <= 1'b0;
    end else begin
      if (do_push) wp <= wp + PTR_W'(1);
      if (do_pop)  rp <= rp + PTR_W'(1);
      cnt      <= cnt_nx;
      ovf_evt  <= wr_valid && !do_push;
      tout_evt <= (cnt_nx == '0) ? 1'b0
                : (tout_evt || (tout_en && idle > IDLE_W'(tout_thr)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      idle    <= '0;
    end else if (restart) begin
      bit_cnt <= '0;
      idle    <= '0;
    end else if (char_end) begin
      bit_cnt <= '0;
      if (idle != '1) idle <= idle + IDLE_W'(1);
    end else if (bit_tick) begin
      bit_cnt <= bit_cnt + FRM_W'(1);
    end
  end

  assign rd_data  = empty ? 8'h00 : mem[rp];
  assign fill     = cnt;
  assign rts      = rts_en && (cnt > CNT_W'(rts_thr));
  assign full_evt = cnt > CNT_W'(full_thr);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH)); // R2
  AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_evt) |-> $past(fill) == CNT_W'(DEPTH) && !$past(rd_req)); // R5
  AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && rd_req && fill != '0 |=> $stable(fill)); // R6
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !wr_valid && fill == '0 |=> fill == '0); // R7
  AST_TOUT_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tout_evt |-> fill != '0); // R9
  AST_TOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tout_en && !tout_evt |=> !tout_evt); // R9
endmodule

// File: tb/uart_rx_queue_test.sv
module uart_rx_queue_test;
  localparam int DEPTH  = 16;
  localparam int TOUT_W = 3;
  localparam int FRM_W  = 4;
  localparam int IDLE_MAX = (1 << (TOUT_W + 1)) - 1;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, rd_req = 0, bit_tick = 0, rts_en = 1, tout_en = 1;
  logic [7:0] wr_data = 0;
  logic [3:0] rts_thr = 5, full_thr = 9;
  logic [TOUT_W-1:0] tout_thr = 2;
  logic [FRM_W-1:0] frame_bits = 3;
  logic [7:0] rd_data;
  logic [4:0] fill;
  logic rts, full_evt, ovf_evt, tout_evt;

  int checks = 0, errors = 0;
  byte unsigned q[$];
  int bitc = 0, idle = 0, m_tout = 0, m_ovf = 0;

  always #10 clk = ~clk;

  uart_rx_queue #(.DEPTH(DEPTH), .TOUT_W(TOUT_W), .FRM_W(FRM_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .rd_req(rd_req), .rd_data(rd_data), .fill(fill), .rts_en(rts_en),
    .rts_thr(rts_thr), .full_thr(full_thr), .tout_en(tout_en),
    .tout_thr(tout_thr), .bit_tick(bit_tick), .frame_bits(frame_bits),
    .rts(rts), .full_evt(full_evt), .ovf_evt(ovf_evt), .tout_evt(tout_evt));

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int n = q.size();
    cmp("R1 rd_data", rd_data, n ? q[0] : 0);
    cmp("R2 fill", fill, n);
    cmp("R3 rts", rts, (rts_en && n > rts_thr) ? 1 : 0);
    cmp("R4 full_evt", full_evt, (n > full_thr) ? 1 : 0);
    cmp("R5 ovf_evt", ovf_evt, m_ovf);
    cmp("R9 tout_evt", tout_evt, m_tout);
  endtask

  task automatic model_edge();
    int n = q.size();
    bit pop  = rd_req && n > 0;
    bit push = wr_valid && (n < DEPTH || pop);
    bit restart = (n == 0) || wr_valid || pop;
    int old_idle = idle;
    m_ovf = (wr_valid && !push) ? 1 : 0;
    if (pop) void'(q.pop_front());
    if (push) q.push_back(wr_data);
    m_tout = (q.size() == 0) ? 0 : ((m_tout || (tout_en && old_idle > tout_thr)) ? 1 : 0);
    if (restart) begin bitc = 0; idle = 0; end
    else if (bit_tick && ((bitc + 1) % (1 << FRM_W)) == frame_bits) begin
      bitc = 0; if (idle < IDLE_MAX) idle++;
    end else if (bit_tick) bitc = (bitc + 1) % (1 << FRM_W);
  endtask

  task automatic step(input bit w, input byte unsigned d, input bit r, input bit t);
    wr_valid = w; wr_data = d; rd_req = r; bit_tick = t;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp("R10 fill", fill, 0); cmp("R10 rd_data", rd_data, 0);
    cmp("R10 rts", rts, 0); cmp("R10 full_evt", full_evt, 0);
    cmp("R10 ovf_evt", ovf_evt, 0); cmp("R10 tout_evt", tout_evt, 0);
    rst_n = 1;
    @(negedge clk);
    // R1 ordering
    for (int i = 0; i < 4; i++) step(1, 8'hA0 + i, 0, 0);
    for (int i = 0; i < 4; i++) begin
      cmp("R1 order", rd_data, 8'hA0 + i);
      step(0, 0, 1, 0);
    end
    // R7 pop on empty
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    cmp("R7 empty fill", fill, 0); cmp("R7 empty data", rd_data, 0);
    // R3 R4 sweep to full, then R5 overflow
    for (int i = 0; i < DEPTH; i++) step(1, 8'h10 + i, 0, 0);
    step(1, 8'hEE, 0, 0);
    cmp("R5 ovf pulse", ovf_evt, 1); cmp("R5 fill held", fill, DEPTH);
    step(0, 0, 0, 0);
    cmp("R5 ovf single", ovf_evt, 0);
    // R6 push and pop at full
    step(1, 8'h77, 1, 0);
    cmp("R6 full pushpop", fill, DEPTH); cmp("R6 head", rd_data, 8'h11);
    // drain, then R8 restart scenario
    while (q.size() > 0) step(0, 0, 1, 0);
    step(1, 8'h01, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1);
    cmp("R8 below limit", tout_evt, 0);
    step(1, 8'h02, 0, 0);
    for (int i = 0; i < 8; i++) step(0, 0, 0, 1);
    cmp("R8 restart on arrival", tout_evt, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
    cmp("R9 tout set", tout_evt, 1);
    step(0, 0, 1, 1);
    cmp("R9 sticky", tout_evt, 1);
    step(0, 0, 1, 0);
    cmp("R9 clears on empty", tout_evt, 0);
    // saturation and disabled timeout
    tout_thr = 7;
    step(1, 8'h33, 0, 0);
    for (int i = 0; i < 60; i++) step(0, 0, 0, 1);
    tout_en = 0;
    step(0, 0, 1, 0);
    step(1, 8'h34, 0, 0);
    for (int i = 0; i < 40; i++) step(0, 0, 0, 1);
    cmp("R9 disabled", tout_evt, 0);
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      if (i % 500 == 0) begin
        rts_en = $urandom_range(1, 0); tout_en = $urandom_range(1, 0);
        rts_thr = 4'($urandom); full_thr = 4'($urandom);
        tout_thr = TOUT_W'($urandom); frame_bits = FRM_W'($urandom_range(5, 1));
      end
      step($urandom_range(99, 0) < ((i / 700) % 2 ? 70 : 30), 8'($urandom),
           $urandom_range(99, 0) < ((i / 700) % 2 ? 30 : 60),
           $urandom_range(99, 0) < 60);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule